// File: doc/BRIEF.md
# Accumulator Bus Cycle Sequencer

This block fetches and executes instructions for a very small 8-bit accumulator machine with a 16-bit address bus. Each clock is one memory cycle. The block drives the address, the write data and a write strobe, and it takes the read data at the clock edge that ends the cycle. It holds an accumulator, an index register Y and negative/zero flags. A side port loads Y directly so that a test can set up indexed accesses.

The block commits to what each bus cycle does before the previous read returns. As a result, a store can write only in its last cycle. An immediate operand is always read from the program counter before the block knows what the byte is for. Half of each zero-page and indexed address is taken straight from a byte that was just read. The store-like immediate opcode $89 therefore reduces to a two-cycle read that has no visible effect.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held, the block drives address $0000 with sync high and write low, and the accumulator and both flags read 0. The first fetch after release is at $0000.
- R2: Opcode $A9 takes two cycles. The first is the opcode fetch at PC. The second reads PC+1, and that byte is loaded into the accumulator. The next fetch is at PC+2.
- R3: Opcode $A5 takes three cycles. The third reads address {$00, operand}, and that byte is loaded into the accumulator.
- R4: Opcode $85 takes three cycles. The opcode fetch and the operand fetch are reads. The third cycle writes the accumulator to {$00, operand}. The accumulator and flags do not change.
- R5: Opcode $B1 with no carry takes five cycles. Cycle 3 reads {$00, p}, where p is the operand. Cycle 4 reads {$00, p+1}, wrapping within page zero. Cycle 5 reads {high, low+Y}, and that byte loads the accumulator. Here low and high are the bytes read in cycles 3 and 4.
- R6: Opcode $B1 whose low+Y carries out of 8 bits takes six cycles. Cycle 5 is a dummy read at {high, (low+Y) mod 256}. Cycle 6 reads {high+1, (low+Y) mod 256}, and only that byte loads the accumulator.
- R7: Opcode $89 takes two cycles. It reads PC+1 and writes nothing. The accumulator, N and Z are left unchanged.
- R8: Any other opcode (for example $02 or $EA) takes two cycles. It reads PC+1 and changes nothing.
- R9: Every load into the accumulator sets Z when the loaded byte is zero and copies bit 7 of the byte into N.
- R10: When yLoad is high at a clock edge, Y takes yIn. Indexed loads use the value Y holds in their fifth cycle.
- R11: sync is high exactly in the opcode fetch cycles.
- R12: The write strobe is high only in the final cycle of a store. An opcode fetch always follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per period |
| rstN | input | 1 | Asynchronous active-low reset |
| rData | input | 8 | Read data, sampled at the edge ending the cycle |
| addr | output | 16 | Address of the current cycle |
| wData | output | 8 | Write data (accumulator) |
| wEn | output | 1 | High in a write cycle |
| sync | output | 1 | High in an opcode fetch cycle |
| yLoad | input | 1 | Load strobe for Y |
| yIn | input | 8 | Value loaded into Y |
| accOut | output | 8 | Accumulator contents |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |

## Verification
Address, sync and the write strobe belong to the cycle in which they are shown, so each is compared in that same cycle. The bench samples at the falling edge, between the rising edges that advance the sequencer. A load takes effect at the edge that ends the instruction's last cycle, so the accumulator and the flags are due in the next opcode fetch cycle and are checked there. A Y value offered at a falling edge is taken at the following rising edge, which comes well before the fifth cycle of the indexed load that uses it.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Opcodes with dedicated sequences; everything else, including the
  // store-immediate pattern $89, falls into the two-cycle default path.
  localparam logic [7:0] OPC_LD_IMM = 8'hA9;
  localparam logic [7:0] OPC_LD_ZP  = 8'hA5;
  localparam logic [7:0] OPC_ST_ZP  = 8'h85;
  localparam logic [7:0] OPC_LD_IND = 8'hB1;

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPND, ST_ZPRD, ST_ZPWR, ST_PLO, ST_PHI, ST_IDX, ST_FIX
  } seqState_t;

  typedef enum logic [2:0] {
    AS_PC,   // program counter
    AS_ZP,   // {00, operand}
    AS_ZP1,  // {00, operand+1}
    AS_IDX,  // {pointer high, pointer low + Y}
    AS_FIX   // {pointer high + 1, latched low sum}
  } addrSel_t;

  typedef struct packed {
    addrSel_t addrSel;
    logic     pcInc;
    logic     latchOpnd;
    logic     latchLo;
    logic     latchHi;
    logic     loadA;
    logic     write;
  } strobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rData,
  input  logic              idxCarry,
  output strobe_t           strobe,
  output logic              sync
);
  seqState_t state, nextState;
  logic [DATA_W-1:0] opcode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_FETCH;
      opcode <= '0;
    end else begin
      state <= nextState;
      if (state == ST_FETCH) opcode <= rData;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.addrSel = AS_PC;
    nextState      = ST_FETCH;
    unique case (state)
      ST_FETCH: begin
        strobe.pcInc = 1'b1;
        nextState    = ST_OPND;
      end
      ST_OPND: begin
        // always a read at PC; meaning of the byte is decided as it arrives
        strobe.pcInc     = 1'b1;
        strobe.latchOpnd = 1'b1;
        case (opcode)
          OPC_LD_IMM: strobe.loadA = 1'b1;
          OPC_LD_ZP:  nextState = ST_ZPRD;
          OPC_ST_ZP:  nextState = ST_ZPWR;
          OPC_LD_IND: nextState = ST_PLO;
          default:    nextState = ST_FETCH;
        endcase
      end
      ST_ZPRD: begin
        strobe.addrSel = AS_ZP;
        strobe.loadA   = 1'b1;
      end
      ST_ZPWR: begin
        strobe.addrSel = AS_ZP;
        strobe.write   = 1'b1;
      end
      ST_PLO: begin
        strobe.addrSel = AS_ZP;
        strobe.latchLo = 1'b1;
        nextState      = ST_PHI;
      end
      ST_PHI: begin
        strobe.addrSel = AS_ZP1;
        strobe.latchHi = 1'b1;
        nextState      = ST_IDX;
      end
      ST_IDX: begin
        strobe.addrSel = AS_IDX;
        if (idxCarry) nextState = ST_FIX;
        else          strobe.loadA = 1'b1;
      end
      ST_FIX: begin
        strobe.addrSel = AS_FIX;
        strobe.loadA   = 1'b1;
      end
      default: nextState = ST_FETCH;
    endcase
  end

  assign sync = (state == ST_FETCH);

  // a fix-up cycle is only entered straight out of an indexed read
  AST_FIX_AFTER_IDX: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX) |-> ($past(state) == ST_IDX && $past(idxCarry))); // R6
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [DATA_W-1:0]   rData,
  input  logic                yLoad,
  input  logic [DATA_W-1:0]   yIn,
  output logic [2*DATA_W-1:0] addr,
  output logic [DATA_W-1:0]   wData,
  output logic                wEn,
  output logic                idxCarry,
  output logic [DATA_W-1:0]   accOut,
  output logic                flagN,
  output logic                flagZ
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] opnd, ptrLo, ptrHi, fixLo, accReg, yReg;
  logic              nFlag, zFlag;
  logic [DATA_W:0]   idxSum;

  assign idxSum   = {1'b0, ptrLo} + {1'b0, yReg};
  assign idxCarry = idxSum[DATA_W];

  always_comb begin
    unique case (strobe.addrSel)
      AS_ZP:   addr = {{DATA_W{1'b0}}, opnd};
      AS_ZP1:  addr = {{DATA_W{1'b0}}, opnd + DATA_W'(1)};
      AS_IDX:  addr = {ptrHi, idxSum[DATA_W-1:0]};
      AS_FIX:  addr = {ptrHi + DATA_W'(1), fixLo};
      default: addr = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= '0;
      opnd   <= '0;
      ptrLo  <= '0;
      ptrHi  <= '0;
      fixLo  <= '0;
      accReg <= '0;
      yReg   <= '0;
      nFlag  <= 1'b0;
      zFlag  <= 1'b0;
    end else begin
      if (strobe.pcInc)     pc    <= pc + ADDR_W'(1);
      if (strobe.latchOpnd) opnd  <= rData;
      if (strobe.latchLo)   ptrLo <= rData;
      if (strobe.latchHi)   ptrHi <= rData;
      if (strobe.addrSel == AS_IDX) fixLo <= idxSum[DATA_W-1:0];
      if (yLoad) yReg <= yIn;
      if (strobe.loadA) begin
        accReg <= rData;
        nFlag  <= rData[DATA_W-1];
        zFlag  <= (rData == '0);
      end
    end
  end

  assign wData  = accReg;
  assign wEn    = strobe.write;
  assign accOut = accReg;
  assign flagN  = nFlag;
  assign flagZ  = zFlag;

  // corrected read keeps the low byte and bumps only the high byte
  AST_FIX_PAGE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.addrSel == AS_FIX) |->
      (addr[ADDR_W-1:DATA_W] == $past(addr[ADDR_W-1:DATA_W]) + DATA_W'(1)
       && addr[DATA_W-1:0] == $past(addr[DATA_W-1:0]))); // R6
  // a store never disturbs the accumulator
  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    wEn |=> $stable(accOut)); // R4
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wData,
  output logic              wEn,
  output logic              sync,
  input  logic              yLoad,
  input  logic [DATA_W-1:0] yIn,
  output logic [DATA_W-1:0] accOut,
  output logic              flagN,
  output logic              flagZ
);
  strobe_t strobe;
  logic    idxCarry;

  seq_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rData(rData), .idxCarry(idxCarry),
    .strobe(strobe), .sync(sync)
  );

  seq_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rData(rData),
    .yLoad(yLoad), .yIn(yIn), .addr(addr), .wData(wData), .wEn(wEn),
    .idxCarry(idxCarry), .accOut(accOut), .flagN(flagN), .flagZ(flagZ)
  );

  AST_WRITE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    wEn |=> sync); // R12
  AST_WRITE_IN_PAGE0: assert property (@(posedge clk) disable iff (!rstN)
    wEn |-> (addr[ADDR_W-1:DATA_W] == '0 && !sync)); // R4
  AST_SECOND_BYTE_AT_PC: assert property (@(posedge clk) disable iff (!rstN)
    sync |=> (!wEn && !sync && addr == $past(addr) + ADDR_W'(1))); // R11
  AST_STIMM_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (sync && rData == 8'h89) |=> !wEn ##1
      (sync && $stable(accOut) && $stable(flagN) && $stable(flagZ))); // R7
endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [15:0] addr;
    logic        sync;
    logic        wEn;
    logic [7:0]  wData;
    logic        setY;
    logic [7:0]  yVal;
    logic [7:0]  a;
    logic        n;
    logic        z;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] rData;
  logic [15:0] addr;
  logic [7:0] wData, yIn = 8'h00, accOut;
  logic wEn, sync, flagN, flagZ, yLoad = 1'b0;

  logic [7:0] mem [0:1023];
  logic [7:0] refMem [0:1023];
  item_t expQ[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] mPc = 16'h0000;
  logic [7:0]  mA = 0, mY = 0;
  logic        mN = 0, mZ = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq dut (
    .clk(clk), .rstN(rstN), .rData(rData), .addr(addr), .wData(wData),
    .wEn(wEn), .sync(sync), .yLoad(yLoad), .yIn(yIn), .accOut(accOut),
    .flagN(flagN), .flagZ(flagZ)
  );

  assign rData = mem[addr[9:0]];
  always @(posedge clk) if (wEn) mem[addr[9:0]] <= wData;

  task automatic push(input logic [15:0] a, input logic s, input logic w,
                      input logic [7:0] d, input logic sy, input logic [7:0] yv,
                      input string tag);
    item_t it;
    it.addr = a; it.sync = s; it.wEn = w; it.wData = d;
    it.setY = sy; it.yVal = yv; it.a = mA; it.n = mN; it.z = mZ; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic place(input logic [7:0] b);
    mem[mPc[9:0]] = b;
    refMem[mPc[9:0]] = b;
    mPc = mPc + 16'd1;
  endtask

  task automatic setA(input logic [7:0] v);
    mA = v; mN = v[7]; mZ = (v == 8'h00);   // R9
  endtask

  // opcode fetch + operand fetch, common to every instruction
  task automatic head(input logic [7:0] op, input logic [7:0] arg,
                      input logic sy, input logic [7:0] yv, input string tag);
    push(mPc, 1'b1, 1'b0, 8'h00, sy, yv, tag);
    place(op);
    push(mPc, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, tag);
    place(arg);
  endtask

  task automatic ldImm(input logic [7:0] v, input string tag);
    head(8'hA9, v, 1'b0, 8'h00, tag);
    setA(v);
  endtask

  task automatic ldZp(input logic [7:0] zp, input string tag);
    head(8'hA5, zp, 1'b0, 8'h00, tag);
    push({8'h00, zp}, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, tag);
    setA(refMem[{2'b00, zp}]);
  endtask

  task automatic stZp(input logic [7:0] zp, input string tag);
    head(8'h85, zp, 1'b0, 8'h00, tag);
    push({8'h00, zp}, 1'b0, 1'b1, mA, 1'b0, 8'h00, tag);
    refMem[{2'b00, zp}] = mA;
  endtask

  task automatic ldInd(input logic [7:0] ptr, input logic [7:0] yv, input string tag);
    logic [7:0] lo, hi, p1;
    logic [8:0] sum;
    logic [15:0] ea;
    head(8'hB1, ptr, 1'b1, yv, tag);
    mY = yv;   // R10: taken at the edge ending the fetch cycle
    p1 = ptr + 8'd1;
    lo = refMem[{2'b00, ptr}];
    hi = refMem[{2'b00, p1}];
    push({8'h00, ptr}, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, tag);
    push({8'h00, p1}, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, tag);
    sum = {1'b0, lo} + {1'b0, mY};
    ea = {hi, sum[7:0]};
    push(ea, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, tag);
    if (sum[8]) begin
      ea = {hi + 8'd1, sum[7:0]};
      push(ea, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, tag);
    end
    setA(refMem[ea[9:0]]);
  endtask

  task automatic inert(input logic [7:0] op, input logic [7:0] arg, input string tag);
    head(op, arg, 1'b0, 8'h00, tag);
  endtask

  task automatic compare(input item_t e);
    bit bad;
    checks++;
    bad = (addr !== e.addr) || (sync !== e.sync) || (wEn !== e.wEn)
       || (e.wEn && wData !== e.wData)
       || (e.sync && (accOut !== e.a || flagN !== e.n || flagZ !== e.z));
    if (bad) begin
      fails++;
      $display("FAIL %s: got addr=%h sync=%b wEn=%b wData=%h A=%h N=%b Z=%b; exp addr=%h sync=%b wEn=%b wData=%h A=%h N=%b Z=%b",
               e.tag, addr, sync, wEn, wData, accOut, flagN, flagZ,
               e.addr, e.sync, e.wEn, e.wData, e.a, e.n, e.z);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'h00;
      refMem[i] = 8'h00;
    end
    // data: $90 overwritten by store, $91 zero, pointers at $A0, $A2, $FF
    mem[10'h0A0] = 8'h10; mem[10'h0A1] = 8'h01;
    mem[10'h0A2] = 8'h30; mem[10'h0A3] = 8'h01;
    mem[10'h0FF] = 8'h40;
    mem[10'h115] = 8'h7F;
    mem[10'h120] = 8'h11;
    mem[10'h220] = 8'h99;
    mem[10'h242] = 8'h00;
    mem[10'h092] = 8'h5A;
    for (int i = 0; i < 1024; i++) refMem[i] = mem[i];

    // byte at $0000 is the high pointer byte for the wrapped pointer at $FF
    inert(8'h02, 8'h55, "R8 unsupported $02");
    ldImm(8'h00, "R2/R9 imm zero");
    ldImm(8'h80, "R2/R9 imm negative");
    inert(8'h89, 8'h00, "R7 store-imm pattern");
    stZp(8'h90, "R4/R12 zp store");
    ldImm(8'h01, "R2 imm positive");
    ldZp(8'h90, "R3 zp load of stored byte");
    ldZp(8'h91, "R3/R9 zp load zero");
    ldInd(8'hA0, 8'h05, "R5/R10 indexed no carry");
    ldInd(8'hA2, 8'hF0, "R6/R10 indexed carry");
    ldInd(8'hFF, 8'h02, "R5 pointer wrap in page zero");
    inert(8'hEA, 8'h12, "R8 unsupported $EA");
    stZp(8'h92, "R4 store zero value");
    ldImm(8'hC3, "R2/R9 imm");
    ldZp(8'h92, "R3 reload stored zero");
    push(mPc, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R11 final fetch");

    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (addr !== 16'h0000 || sync !== 1'b1 || wEn !== 1'b0 ||
        accOut !== 8'h00 || flagN !== 1'b0 || flagZ !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got addr=%h sync=%b wEn=%b A=%h N=%b Z=%b; exp addr=0000 sync=1 wEn=0 A=00 N=0 Z=0",
               addr, sync, wEn, accOut, flagN, flagZ);
    end
    rstN = 1'b1;

    // monitor: one expected item per bus cycle
    while (expQ.size() > 0) begin
      item_t e;
      e = expQ.pop_front();
      compare(e);
      yLoad = e.setY;
      yIn   = e.yVal;
      @(negedge clk);
      yLoad = 1'b0;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got run still active; exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule